// File: doc/BRIEF.md
# Low-Power Mode Register with Bus Pin Override

This block holds the power-control byte of an 8051-style microcontroller. Software writes it through the byte-wide special-function-register port at one address and reads it back at the same address. Two of its bits request the idle and power-down modes. The block turns these requests into clock-enable outputs for the CPU and for the peripherals. An interrupt ends idle. A wake-up input or reset ends power-down.

While a low-power mode is active, the block sits between the core's bus outputs and the pins. It forces the address-latch and program-store strobes to fixed levels. It releases port 0 when code runs from external memory. It chooses what port 2 drives: the last address high byte or the port latch. The remaining bits go out as plain controls: serial baud doubling, aux-RAM bypass, address-latch strobe suppression, and a watchdog reload enable that clears itself when the watchdog is reloaded.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the register reads 0x00, both clock enables are 1, idle_mode and pd_mode are 0, and every pin output follows its core input.
- R2: A write with sfr_we=1 at sfr_addr=0x87 stores all eight bits. Reading with sfr_addr=0x87 returns them. A write to any other address changes nothing. Bit map: 7 baud double, 6 aux-RAM off, 5 strobe quiet, 4 watchdog-load enable, 3 and 2 general flags, 1 power-down, 0 idle.
- R3: A mode bit takes effect on the clock edge that completes the write. In idle, cpu_clk_en is 0 and periph_clk_en is 1. In power-down, both are 0.
- R4: A write that sets both bit 1 and bit 0 enters power-down only, so idle_mode stays 0.
- R5: irq_wake during idle clears bit 0 on the next edge and ends idle. irq_wake during power-down has no effect.
- R6: ext_wake during power-down clears bits 1 and 0 on the next edge, which restores normal mode.
- R7: A wdt_load pulse clears bit 4 on the next edge. If a write and wdt_load occur in the same cycle, the bit ends up 0.
- R8: In idle, ale_pin and psen_pin are 1. In power-down, both are 0. This holds for either value of ext_mem.
- R9: In normal mode with bit 5 set, ale_pin is held at 0 whatever ale_core does. With bit 5 clear, ale_pin follows ale_core.
- R10: With ext_mem=1 in either low-power mode, p0_oe is 0. In every other case p0_oe follows p0_core_oe.
- R11: With ext_mem=1 in idle, p2_out drives addr_hi. In any other low-power case it drives p2_latch. In normal mode it drives p2_core_out.
- R12: baud_x2 equals bit 7, aux_ram_off equals bit 6, and wle_flag equals bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | SFR address |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Register value when sfr_addr matches, else 0 |
| wdt_load | input | 1 | Watchdog reload strobe |
| irq_wake | input | 1 | Enabled interrupt pending |
| ext_wake | input | 1 | Power-down wake-up request |
| ext_mem | input | 1 | 1 when code runs from external memory |
| ale_core | input | 1 | Address-latch strobe from the core |
| psen_core | input | 1 | Program-store strobe from the core |
| p0_core_out | input | 8 | Port 0 value from the core |
| p0_core_oe | input | 1 | Port 0 drive enable from the core |
| p2_core_out | input | 8 | Port 2 value from the core |
| p2_latch | input | 8 | Port 2 latch data |
| addr_hi | input | 8 | Last address high byte |
| ale_pin | output | 1 | Address-latch strobe pin |
| psen_pin | output | 1 | Program-store strobe pin |
| p0_out | output | 8 | Port 0 pin value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 pin value |
| idle_mode | output | 1 | Idle active |
| pd_mode | output | 1 | Power-down active |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| baud_x2 | output | 1 | Serial baud doubling |
| aux_ram_off | output | 1 | Route all MOVX accesses to external data memory |
| wle_flag | output | 1 | Watchdog reload enable |

## Verification
The bench builds the block with its default parameters: an 8-bit address, register address 0x87, 8-bit ports and a quiet strobe level of 0. With a byte-wide register, all 256 write values can be swept. Each value is checked against every combination of ext_mem, ale_core, psen_core and p0_core_oe, and then again after each wake-up or reload pulse that applies to it. This sweep covers every pairing of the mode bits with the strobe-quiet bit and the memory source. Writes to a neighbouring address and a write that coincides with a reload pulse are exercised as directed cases.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   localparam int unsigned REG_W = 8;

   typedef struct packed {
      logic baud_dbl;
      logic aux_off;
      logic ale_quiet;
      logic wdt_ld_en;
      logic flag1;
      logic flag0;
      logic pdown;
      logic idle;
   } pwr_reg_t;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'b00,
      MODE_IDLE = 2'b01,
      MODE_PD   = 2'b10
   } pwr_mode_e;
endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
   import pwr_mode_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SFR_ADDR = 'h87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_we,
   input  logic [REG_W-1:0]  sfr_wdata,
   input  logic              wdt_load,
   input  logic              irq_wake,
   input  logic              ext_wake,
   output pwr_reg_t          reg_q,
   output logic [REG_W-1:0]  sfr_rdata
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SFR_ADDR);

   logic     addr_hit;
   pwr_reg_t reg_d;

   assign addr_hit = (sfr_addr == MY_ADDR);

   always_comb begin
      reg_d = reg_q;
      if (sfr_we && addr_hit) reg_d = pwr_reg_t'(sfr_wdata);
      // an interrupt only reaches a core that is idling, not one in power-down
      if (irq_wake && reg_q.idle && !reg_q.pdown) reg_d.idle = 1'b0;
      if (ext_wake && reg_q.pdown) begin
         reg_d.pdown = 1'b0;
         reg_d.idle  = 1'b0;
      end
      if (wdt_load) reg_d.wdt_ld_en = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= reg_d;
   end

   assign sfr_rdata = addr_hit ? REG_W'(reg_q) : '0;
endmodule

// File: rtl/pwr_pin_override.sv
module pwr_pin_override
   import pwr_mode_pkg::*;
#(
   parameter int unsigned P0_W           = 8,
   parameter int unsigned P2_W           = 8,
   parameter bit          ALE_QUIET_HIGH = 1'b0
) (
   input  pwr_reg_t        reg_q,
   input  logic            ext_mem,
   input  logic            ale_core,
   input  logic            psen_core,
   input  logic [P0_W-1:0] p0_core_out,
   input  logic            p0_core_oe,
   input  logic [P2_W-1:0] p2_core_out,
   input  logic [P2_W-1:0] p2_latch,
   input  logic [P2_W-1:0] addr_hi,
   output pwr_mode_e       mode,
   output logic            ale_pin,
   output logic            psen_pin,
   output logic [P0_W-1:0] p0_out,
   output logic            p0_oe,
   output logic [P2_W-1:0] p2_out
);
   logic quiet_lvl;

   generate
      if (ALE_QUIET_HIGH) begin : g_quiet_hi
         assign quiet_lvl = 1'b1;
      end else begin : g_quiet_lo
         assign quiet_lvl = 1'b0;
      end
   endgenerate

   // power-down outranks idle when both bits are set
   always_comb begin
      if (reg_q.pdown)     mode = MODE_PD;
      else if (reg_q.idle) mode = MODE_IDLE;
      else                 mode = MODE_RUN;
   end

   always_comb begin
      p0_out = p0_core_out;
      unique case (mode)
         MODE_IDLE: begin
            ale_pin  = 1'b1;
            psen_pin = 1'b1;
            p0_oe    = ext_mem ? 1'b0 : p0_core_oe;
            p2_out   = ext_mem ? addr_hi : p2_latch;
         end
         MODE_PD: begin
            ale_pin  = 1'b0;
            psen_pin = 1'b0;
            p0_oe    = ext_mem ? 1'b0 : p0_core_oe;
            p2_out   = p2_latch;
         end
         default: begin
            ale_pin  = reg_q.ale_quiet ? quiet_lvl : ale_core;
            psen_pin = psen_core;
            p0_oe    = p0_core_oe;
            p2_out   = p2_core_out;
         end
      endcase
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned SFR_ADDR       = 'h87,
   parameter int unsigned P0_W           = 8,
   parameter int unsigned P2_W           = 8,
   parameter bit          ALE_QUIET_HIGH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_we,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   input  logic              wdt_load,
   input  logic              irq_wake,
   input  logic              ext_wake,
   input  logic              ext_mem,
   input  logic              ale_core,
   input  logic              psen_core,
   input  logic [P0_W-1:0]   p0_core_out,
   input  logic              p0_core_oe,
   input  logic [P2_W-1:0]   p2_core_out,
   input  logic [P2_W-1:0]   p2_latch,
   input  logic [P2_W-1:0]   addr_hi,
   output logic              ale_pin,
   output logic              psen_pin,
   output logic [P0_W-1:0]   p0_out,
   output logic              p0_oe,
   output logic [P2_W-1:0]   p2_out,
   output logic              idle_mode,
   output logic              pd_mode,
   output logic              cpu_clk_en,
   output logic              periph_clk_en,
   output logic              baud_x2,
   output logic              aux_ram_off,
   output logic              wle_flag
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("pwr_mode_ctrl: ADDR_W out of range");
      end
      if (SFR_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("pwr_mode_ctrl: SFR_ADDR does not fit ADDR_W");
      end
      if (P0_W < 1 || P2_W < 1) begin : g_bad_port_w
         $error("pwr_mode_ctrl: port widths must be at least 1");
      end
   endgenerate

   pwr_reg_t  reg_q;
   pwr_mode_e mode;

   pwr_mode_reg #(
      .ADDR_W  (ADDR_W),
      .SFR_ADDR(SFR_ADDR)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sfr_addr (sfr_addr),
      .sfr_we   (sfr_we),
      .sfr_wdata(sfr_wdata),
      .wdt_load (wdt_load),
      .irq_wake (irq_wake),
      .ext_wake (ext_wake),
      .reg_q    (reg_q),
      .sfr_rdata(sfr_rdata)
   );

   pwr_pin_override #(
      .P0_W          (P0_W),
      .P2_W          (P2_W),
      .ALE_QUIET_HIGH(ALE_QUIET_HIGH)
   ) u_pins (
      .reg_q      (reg_q),
      .ext_mem    (ext_mem),
      .ale_core   (ale_core),
      .psen_core  (psen_core),
      .p0_core_out(p0_core_out),
      .p0_core_oe (p0_core_oe),
      .p2_core_out(p2_core_out),
      .p2_latch   (p2_latch),
      .addr_hi    (addr_hi),
      .mode       (mode),
      .ale_pin    (ale_pin),
      .psen_pin   (psen_pin),
      .p0_out     (p0_out),
      .p0_oe      (p0_oe),
      .p2_out     (p2_out)
   );

   assign idle_mode     = (mode == MODE_IDLE);
   assign pd_mode       = (mode == MODE_PD);
   assign cpu_clk_en    = (mode == MODE_RUN);
   assign periph_clk_en = (mode != MODE_PD);
   assign baud_x2       = reg_q.baud_dbl;
   assign aux_ram_off   = reg_q.aux_off;
   assign wle_flag      = reg_q.wdt_ld_en;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SFR_ADDR = 'h87
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sfr_addr,
   input logic              sfr_we,
   input logic [7:0]        sfr_wdata,
   input logic              wdt_load,
   input logic              irq_wake,
   input logic              ext_wake,
   input logic              ext_mem,
   input logic              ale_pin,
   input logic              psen_pin,
   input logic              p0_oe,
   input logic              idle_mode,
   input logic              pd_mode,
   input logic              cpu_clk_en,
   input logic              periph_clk_en,
   input logic              wle_flag
);
   logic wr_hit;
   assign wr_hit = sfr_we && (sfr_addr == ADDR_W'(SFR_ADDR));

   AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      pd_mode |-> (!cpu_clk_en && !periph_clk_en)); // R3
   AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_mode |-> (!cpu_clk_en && periph_clk_en)); // R3
   AST_WRITE_PD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && sfr_wdata[1] && !ext_wake) |=> pd_mode); // R3
   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !(idle_mode && pd_mode)); // R4
   AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_mode && irq_wake && !wr_hit) |=> !idle_mode); // R5
   AST_PD_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode && irq_wake && !ext_wake && !wr_hit) |=> pd_mode); // R5
   AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode && ext_wake && !wr_hit) |=> (!pd_mode && !idle_mode)); // R6
   AST_WLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_load |=> !wle_flag); // R7
   AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      idle_mode |-> (ale_pin && psen_pin)); // R8
   AST_PD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      pd_mode |-> (!ale_pin && !psen_pin)); // R8
   AST_P0_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((idle_mode || pd_mode) && ext_mem) |-> !p0_oe); // R10
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(
   .ADDR_W  (ADDR_W),
   .SFR_ADDR(SFR_ADDR)
) u_chk (.*);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = 8'h87;
   logic       sfr_we = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       wdt_load = 1'b0, irq_wake = 1'b0, ext_wake = 1'b0;
   logic       ext_mem = 1'b0, ale_core = 1'b0, psen_core = 1'b0, p0_core_oe = 1'b0;
   logic [7:0] p0_core_out = 8'hA5, p2_core_out = 8'h3C, p2_latch = 8'hC3, addr_hi = 8'h5A;
   logic       ale_pin, psen_pin, p0_oe, idle_mode, pd_mode;
   logic       cpu_clk_en, periph_clk_en, baud_x2, aux_ram_off, wle_flag;
   logic [7:0] p0_out, p2_out;

   int checks = 0;
   int failures = 0;
   logic [7:0] m;

   always #4 clk = ~clk;

   pwr_mode_ctrl dut (.*);

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare every output with values derived from model byte m
   task automatic check_pins();
      logic idl, pd, run;
      pd  = m[1];
      idl = m[0] & ~m[1];
      run = ~(idl | pd);
      chk("R2", "rdata", sfr_rdata, m);
      chk("R4", "idle_mode", {7'd0, idle_mode}, {7'd0, idl});
      chk("R3", "pd_mode", {7'd0, pd_mode}, {7'd0, pd});
      chk("R3", "cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, run});
      chk("R3", "periph_clk_en", {7'd0, periph_clk_en}, {7'd0, ~pd});
      chk("R8_R9", "ale_pin", {7'd0, ale_pin},
          {7'd0, pd ? 1'b0 : idl ? 1'b1 : m[5] ? 1'b0 : ale_core});
      chk("R8", "psen_pin", {7'd0, psen_pin},
          {7'd0, pd ? 1'b0 : idl ? 1'b1 : psen_core});
      chk("R10", "p0_oe", {7'd0, p0_oe}, {7'd0, (ext_mem && !run) ? 1'b0 : p0_core_oe});
      chk("R10", "p0_out", p0_out, p0_core_out);
      chk("R11", "p2_out", p2_out, run ? p2_core_out : (ext_mem && idl) ? addr_hi : p2_latch);
      chk("R12", "baud_x2", {7'd0, baud_x2}, {7'd0, m[7]});
      chk("R12", "aux_ram_off", {7'd0, aux_ram_off}, {7'd0, m[6]});
      chk("R12", "wle_flag", {7'd0, wle_flag}, {7'd0, m[4]});
   endtask

   task automatic sweep_inputs();
      for (int k = 0; k < 16; k++) begin
         {ext_mem, ale_core, psen_core, p0_core_oe} = 4'(k);
         #1;
         check_pins();
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic ld);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1; wdt_load = ld;
      @(negedge clk);
      sfr_we = 1'b0; wdt_load = 1'b0; sfr_addr = 8'h87;
   endtask

   task automatic pulse(input logic irq, input logic ew, input logic ld);
      @(negedge clk);
      irq_wake = irq; ext_wake = ew; wdt_load = ld;
      @(negedge clk);
      irq_wake = 1'b0; ext_wake = 1'b0; wdt_load = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m = 8'h00;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      m = 8'h00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      sweep_inputs(); // R1 reset state
      for (int v = 0; v < 256; v++) begin
         do_reset();
         sweep_inputs(); // R1
         do_write(8'h86, 8'(v), 1'b0); // R2 other address ignored
         sweep_inputs();
         do_write(8'h87, 8'(v), 1'b0); // R2 R3 R4 effect after the write edge
         m = 8'(v);
         sweep_inputs();
         pulse(1'b1, 1'b0, 1'b0); // R5 interrupt wake
         if (!m[1]) m[0] = 1'b0;
         sweep_inputs();
         pulse(1'b0, 1'b1, 1'b0); // R6 external wake
         if (m[1]) m[1:0] = 2'b00;
         sweep_inputs();
         pulse(1'b0, 1'b0, 1'b1); // R7 watchdog reload clears enable
         m[4] = 1'b0;
         sweep_inputs();
      end
      do_reset();
      do_write(8'h87, 8'h10, 1'b1); // R7 write and reload in one cycle
      m = 8'h00;
      sweep_inputs();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule